// File: doc/BRIEF.md
# Dual-Buffer Scanout Address Sequencer

This block produces the read addresses for a display fetch engine that keeps the pixel FIFO filled from one of two framebuffer regions. Each region has a programmable base word address and a ceiling word address. While the raster is enabled, the sequencer issues fixed-length read bursts from the active region. When the next burst would pass the ceiling, it raises that region's end-of-frame flag and moves to the other region. In single-buffer mode it returns to region 0.

A region's base and ceiling are copied into the working address registers only when the sequencer enters that region. Software can therefore retarget one buffer while the other is being fetched. The block also holds sticky status flags for underflow, sync loss and palette-load completion, together with an interrupt line. When underflow and sync loss are both flagged, fetching halts until software stops the raster, clears the flags and enables it again.

The controller has three states. SEQ_IDLE waits for the raster enable. SEQ_FETCH issues bursts. SEQ_HALT holds after the combined error. The transitions are:
- idle-to-fetch on enable, which loads region 0.
- fetch-to-idle when the raster is disabled.
- fetch-to-halt and idle-to-halt on the combined error.
- halt-to-idle once the raster is off and the error flags are clear.

Top module: `scanout_seq`

## Requirements
- R1: Writes with `reg_wr_sel` 0, 1, 2 and 3 set region 0 base, region 0 ceiling, region 1 base and region 1 ceiling. A region's values are used only from the next entry into that region, never in the middle of a region.
- R2: The first request after the raster is enabled (from idle) is at region 0's base. Each accepted request (`rd_req && rd_ack`) advances the address by the burst length in words.
- R3: `rd_req` is high in the fetch state exactly when the raster is enabled, the burst code is legal and `fifo_level <= fifo_thresh`.
- R4: `burst_code` values 0 to 4 give a burst length of 1, 2, 4, 8 or 16 words on `rd_len`. Codes 5 to 7 are illegal and produce no request.
- R5: When an accepted burst's next address would exceed the active ceiling, `status` bit 0 (region 0) or bit 1 (region 1) is set. With `dual_en` high, the next address is the other region's base.
- R6: With `dual_en` low, a finished region 0 reloads from region 0's base.
- R7: `pix_pop` with `fifo_level == 0` sets `status` bit 2 (underflow).
- R8: A `sync_lost` pulse sets `status` bit 3. When bits 2 and 3 are both set, no request is issued from the next cycle on. Fetching resumes at region 0's base only after the raster enable is low, both bits are cleared, and the raster is enabled again.
- R9: `pal_done` sets `status` bit 4. Every status bit clears when the same bit is written as 1 on `stat_clr`, and a set in the same cycle as a clear wins. `irq` is high whenever any status bit is set.
- R10: After reset, `status` is 0, `irq` is 0 and `rd_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raster_en | input | 1 | Raster enable |
| dual_en | input | 1 | Alternate between both regions when high |
| burst_code | input | 3 | Burst length code, 0..4 legal |
| fifo_thresh | input | LW | Request threshold on FIFO fill level |
| reg_wr_en | input | 1 | Region register write strobe |
| reg_wr_sel | input | 2 | 0 base0, 1 ceil0, 2 base1, 3 ceil1 |
| reg_wr_data | input | AW | Word address to write |
| fifo_level | input | LW | Current pixel FIFO fill level |
| pix_pop | input | 1 | Pixel consumer asks for data |
| sync_lost | input | 1 | Sync-lost event pulse |
| pal_done | input | 1 | Palette-load-done event pulse |
| stat_clr | input | 5 | Write-one-to-clear mask for status |
| rd_req | output | 1 | Burst read request |
| rd_ack | input | 1 | Request accepted this cycle |
| rd_addr | output | AW | Burst start word address |
| rd_len | output | 5 | Burst length in words |
| status | output | 5 | Sticky flags: eof0, eof1, underflow, sync lost, palette done |
| irq | output | 1 | Any status flag set |

## Verification
A register write can land in the same cycle in which the sequencer enters the region that register belongs to. The random phase writes region registers at random times while short regions wrap often. The reference model latches the value held before the write at each entry and compares every accepted address against it. A status set can also coincide with a software clear of the same bit. This happens when the end-of-frame flag is acknowledged in the cycle another wrap occurs, and a directed case pops an empty FIFO while clearing the underflow bit. The flag must remain set in both cases.

// File: rtl/scanout_pkg.sv
package scanout_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_HALT  = 2'd2
    } seq_state_e;

    localparam int STAT_W  = 5;
    localparam int LEN_W   = 5;
    localparam int S_EOF0  = 0;
    localparam int S_EOF1  = 1;
    localparam int S_UFLOW = 2;
    localparam int S_SLOST = 3;
    localparam int S_PALD  = 4;

    function automatic logic code_ok(input logic [2:0] c);
        return c <= 3'd4;
    endfunction

    function automatic logic [LEN_W-1:0] code_words(input logic [2:0] c);
        return code_ok(c) ? (LEN_W'(1) << c) : '0;
    endfunction
endpackage

// File: rtl/scanout_regbank.sv
module scanout_regbank #(
    parameter int AW   = 16,
    parameter int NREG = 4,
    localparam int SW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SW-1:0]            wr_sel,
    input  logic [AW-1:0]            wr_data,
    output logic [NREG-1:0][AW-1:0]  regs_q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (wr_en && (wr_sel == SW'(i)))
                regs_q[i] <= wr_data;
        end
    end
endmodule

// File: rtl/scanout_status.sv
module scanout_status #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o,
    output logic         irq_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_o[b] <= 1'b0;
            else if (set_i[b])
                status_o[b] <= 1'b1;
            else if (clr_i[b])
                status_o[b] <= 1'b0;
        end
    end

    assign irq_o = |status_o;
endmodule

// File: rtl/scanout_fsm.sv
module scanout_fsm
    import scanout_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raster_en,
    input  logic             dual_en,
    input  logic [2:0]       burst_code,
    input  logic [LW-1:0]    fifo_thresh,
    input  logic [LW-1:0]    fifo_level,
    input  logic             err_hold,
    input  logic [AW-1:0]    base0,
    input  logic [AW-1:0]    ceil0,
    input  logic [AW-1:0]    base1,
    input  logic [AW-1:0]    ceil1,
    input  logic             rd_ack,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    output logic [LEN_W-1:0] rd_len,
    output logic [1:0]       eof_set
);
    seq_state_e st_q, st_d;
    logic [AW-1:0] cur_addr, cur_ceil;
    logic          cur_region;
    logic [AW:0]   nxt_addr;
    logic          wrap, fire, next_region, start;
    logic [AW-1:0] ent_base, ent_ceil;

    assign rd_len      = code_words(burst_code);
    assign nxt_addr    = {1'b0, cur_addr} + {{(AW+1-LEN_W){1'b0}}, rd_len};
    assign wrap        = nxt_addr > {1'b0, cur_ceil};
    assign fire        = rd_req && rd_ack;
    assign next_region = dual_en ? ~cur_region : 1'b0;
    assign ent_base    = next_region ? base1 : base0;
    assign ent_ceil    = next_region ? ceil1 : ceil0;
    assign start       = (st_q == SEQ_IDLE) && (st_d == SEQ_FETCH);
    assign rd_addr     = cur_addr;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE: begin
                if (err_hold)       st_d = SEQ_HALT;
                else if (raster_en) st_d = SEQ_FETCH;
            end
            SEQ_FETCH: begin
                if (err_hold)        st_d = SEQ_HALT;
                else if (!raster_en) st_d = SEQ_IDLE;
            end
            SEQ_HALT: begin
                if (!raster_en && !err_hold) st_d = SEQ_IDLE;
            end
            default: st_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_req  = (st_q == SEQ_FETCH) && raster_en && code_ok(burst_code)
                  && (fifo_level <= fifo_thresh);
        eof_set = 2'b00;
        if (fire && wrap) eof_set[cur_region] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            cur_ceil   <= '0;
            cur_region <= 1'b0;
        end else if (start) begin
            cur_addr   <= base0;
            cur_ceil   <= ceil0;
            cur_region <= 1'b0;
        end else if (fire) begin
            if (wrap) begin
                cur_addr   <= ent_base;
                cur_ceil   <= ent_ceil;
                cur_region <= next_region;
            end else begin
                cur_addr <= nxt_addr[AW-1:0];
            end
        end
    end
endmodule

// File: rtl/scanout_seq.sv
module scanout_seq
    import scanout_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raster_en,
    input  logic              dual_en,
    input  logic [2:0]        burst_code,
    input  logic [LW-1:0]     fifo_thresh,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [AW-1:0]     reg_wr_data,
    input  logic [LW-1:0]     fifo_level,
    input  logic              pix_pop,
    input  logic              sync_lost,
    input  logic              pal_done,
    input  logic [STAT_W-1:0] stat_clr,
    output logic              rd_req,
    input  logic              rd_ack,
    output logic [AW-1:0]     rd_addr,
    output logic [LEN_W-1:0]  rd_len,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [3:0][AW-1:0]  regs;
    logic [1:0]          eof_set;
    logic [STAT_W-1:0]   stat_set;
    logic                err_hold;

    scanout_regbank #(.AW(AW), .NREG(4)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .regs_q  (regs)
    );

    assign err_hold = status[S_UFLOW] && status[S_SLOST];

    scanout_fsm #(.AW(AW), .LW(LW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .raster_en   (raster_en),
        .dual_en     (dual_en),
        .burst_code  (burst_code),
        .fifo_thresh (fifo_thresh),
        .fifo_level  (fifo_level),
        .err_hold    (err_hold),
        .base0       (regs[0]),
        .ceil0       (regs[1]),
        .base1       (regs[2]),
        .ceil1       (regs[3]),
        .rd_ack      (rd_ack),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_len      (rd_len),
        .eof_set     (eof_set)
    );

    always_comb begin
        stat_set          = '0;
        stat_set[S_EOF0]  = eof_set[0];
        stat_set[S_EOF1]  = eof_set[1];
        stat_set[S_UFLOW] = pix_pop && (fifo_level == '0);
        stat_set[S_SLOST] = sync_lost;
        stat_set[S_PALD]  = pal_done;
    end

    scanout_status #(.W(STAT_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (stat_set),
        .clr_i    (stat_clr),
        .status_o (status),
        .irq_o    (irq)
    );
endmodule

// File: rtl/scanout_seq_chk.sv
module scanout_seq_chk #(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    burst_code,
    input logic [LW-1:0] fifo_thresh,
    input logic [LW-1:0] fifo_level,
    input logic          pix_pop,
    input logic [4:0]    stat_clr,
    input logic          rd_req,
    input logic          rd_ack,
    input logic [4:0]    rd_len,
    input logic [4:0]    status
);
    p_req_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (fifo_level <= fifo_thresh));

    p_legal_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (burst_code <= 3'd4) && ($countones(rd_len) == 1));

    p_eof_from_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[0]) || $rose(status[1])) |-> $past(rd_req && rd_ack));

    p_underflow_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_pop && fifo_level == '0) |=> status[2]);

    p_error_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && status[3]) |=> !rd_req);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !stat_clr[4]) |=> status[4]);
endmodule

bind scanout_seq scanout_seq_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_code  (burst_code),
    .fifo_thresh (fifo_thresh),
    .fifo_level  (fifo_level),
    .pix_pop     (pix_pop),
    .stat_clr    (stat_clr),
    .rd_req      (rd_req),
    .rd_ack      (rd_ack),
    .rd_len      (rd_len),
    .status      (status)
);

// File: tb/scanout_seq_tb.sv
module scanout_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          raster_en = 1'b0, dual_en = 1'b0;
    logic [2:0]    burst_code = 3'd2;
    logic [LW-1:0] fifo_thresh = 8'd8, fifo_level = '0;
    logic          reg_wr_en = 1'b0;
    logic [1:0]    reg_wr_sel = '0;
    logic [AW-1:0] reg_wr_data = '0;
    logic          pix_pop = 1'b0, sync_lost = 1'b0, pal_done = 1'b0;
    logic [4:0]    stat_clr = '0;
    logic          rd_ack = 1'b0;
    logic          rd_req, irq;
    logic [AW-1:0] rd_addr;
    logic [4:0]    rd_len, status;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // reference model
    int mb[2], mc[2];
    int m_addr, m_ceil, m_region, m_st;
    logic [4:0] pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    scanout_seq #(.AW(AW), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .dual_en(dual_en),
        .burst_code(burst_code), .fifo_thresh(fifo_thresh),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .fifo_level(fifo_level), .pix_pop(pix_pop), .sync_lost(sync_lost),
        .pal_done(pal_done), .stat_clr(stat_clr), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_addr(rd_addr), .rd_len(rd_len), .status(status), .irq(irq)
    );

    function automatic bit exp_legal(input logic [2:0] c);
        return c < 3'd5;
    endfunction

    function automatic int exp_len(input logic [2:0] c);
        return exp_legal(c) ? (1 << c) : 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock: evaluate the transaction about to happen, then advance
    task automatic cyc();
        bit sw;
        #1;
        if (m_st == 1) begin
            bit er = raster_en && exp_legal(burst_code) && (fifo_level <= fifo_thresh);
            check(rd_req == er, "R3", int'(rd_req), int'(er));
        end
        if (rd_req && rd_ack && m_st != 0) begin
            check(int'(rd_len) == exp_len(burst_code), "R4", int'(rd_len), exp_len(burst_code));
            check(int'(rd_addr) == m_addr, "R2", int'(rd_addr), m_addr);
            sw = (m_addr + exp_len(burst_code)) > m_ceil;
            if (sw) begin
                pend[m_region] = 1'b1;
                m_region = dual_en ? 1 - m_region : 0;
                m_addr = mb[m_region];
                m_ceil = mc[m_region];
            end else begin
                m_addr = m_addr + exp_len(burst_code);
            end
        end
        if (m_st == 0 && raster_en) begin
            m_st = 1; m_region = 0; m_addr = mb[0]; m_ceil = mc[0];
        end else if (m_st == 1 && !raster_en) begin
            m_st = 0;
        end
        if (reg_wr_en) begin
            if (reg_wr_sel[0]) mc[reg_wr_sel[1]] = int'(reg_wr_data);
            else               mb[reg_wr_sel[1]] = int'(reg_wr_data);
        end
        @(posedge clk); @(negedge clk);
        if (pend != 0)
            check((status & pend) == pend, dual_en ? "R5" : "R6", int'(status), int'(pend));
        stat_clr = pend;
        pend = '0;
    endtask

    task automatic wr(input logic [1:0] sel, input int val);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = AW'(val);
        cyc();
        reg_wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        mb = '{0, 0}; mc = '{0, 0};
        m_st = 0; m_addr = 0; m_ceil = 0; m_region = 0; pend = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(status == 5'd0, "R10", int'(status), 0);
        check(irq == 1'b0, "R10", int'(irq), 0);
        check(rd_req == 1'b0, "R10", int'(rd_req), 0);

        // R1 program both regions
        wr(2'd0, 16'h0100); wr(2'd1, 16'h010F);
        wr(2'd2, 16'h0200); wr(2'd3, 16'h0207);

        // R2 enable with dual mode, burst 4
        dual_en = 1'b1; burst_code = 3'd2; fifo_level = 8'd0; rd_ack = 1'b1;
        raster_en = 1'b1;
        cyc();
        #1;
        check(rd_req && int'(rd_addr) == 16'h0100, "R2", int'(rd_addr), 16'h0100);
        repeat (40) cyc();

        // R6 single buffer mode
        dual_en = 1'b0;
        repeat (30) cyc();
        dual_en = 1'b1;

        // R4 illegal burst codes
        burst_code = 3'd6;
        repeat (5) cyc();
        #1; check(rd_req == 1'b0, "R4", int'(rd_req), 0);
        burst_code = 3'd2;

        // R1 write to region being fetched must not disturb it
        wr(2'd1, 16'h0101);
        repeat (20) cyc();

        // random phase: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            fifo_level = 8'($urandom_range(0, 15));
            rd_ack = ($urandom_range(0, 3) != 0);
            if (r < 3) burst_code = 3'($urandom_range(0, 7));
            if (r == 5) dual_en = ~dual_en;
            if (r == 6) fifo_thresh = 8'($urandom_range(0, 12));
            if (r >= 90) begin
                int reg_id = $urandom_range(0, 3);
                int rg = reg_id / 2;
                int v = (reg_id % 2 == 0) ? (rg * 16'h1000 + $urandom_range(0, 255))
                                          : (mb[rg] + $urandom_range(0, 47));
                reg_wr_en = 1'b1; reg_wr_sel = 2'(reg_id); reg_wr_data = AW'(v);
            end
            cyc();
            reg_wr_en = 1'b0;
        end

        // stop and clear everything
        raster_en = 1'b0; rd_ack = 1'b0; burst_code = 3'd2; fifo_thresh = 8'd8;
        cyc();
        stat_clr = 5'h1F; cyc(); cyc();
        check(status == 5'd0 && irq == 1'b0, "R9", int'(status), 0);

        // R9 palette done, W1C
        pal_done = 1'b1; cyc(); pal_done = 1'b0;
        check(status[4] && irq, "R9", int'(status), 5'h10);
        stat_clr = 5'h10; cyc();
        check(status == 5'd0 && !irq, "R9", int'(status), 0);

        // R7 underflow while clearing the same bit: set wins
        fifo_level = 8'd0; pix_pop = 1'b1; stat_clr = 5'h04; cyc();
        pix_pop = 1'b0;
        check(status[2] == 1'b1, "R7", int'(status), 5'h04);

        // R8 sync lost together with underflow halts fetching
        raster_en = 1'b1; fifo_level = 8'd20; cyc();
        sync_lost = 1'b1; cyc(); sync_lost = 1'b0;
        check(status[3:2] == 2'b11, "R8", int'(status), 5'h0C);
        m_st = 2; fifo_level = 8'd0; rd_ack = 1'b1;
        cyc();
        #1; check(rd_req == 1'b0, "R8", int'(rd_req), 0);
        stat_clr = 5'h0C; cyc();
        cyc();
        #1; check(rd_req == 1'b0, "R8", int'(rd_req), 0);
        raster_en = 1'b0; cyc(); cyc(); cyc();
        m_st = 0;
        raster_en = 1'b1; cyc();
        #1; check(rd_req && int'(rd_addr) == mb[0], "R8", int'(rd_addr), mb[0]);
        repeat (20) cyc();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule